// File: doc/BRIEF.md
# Byte-Swapping Configuration Data Port

This block sits on a 64-bit big-endian register bus and gives it indirect access to a little-endian PCI-style configuration space. Software first loads a 64-bit address register whose bits 43:32 carry a configuration offset. It then reads or writes a narrow data port. Each data-port access is turned into a configuration-space access whose offset combines the dword-aligned offset with the low two bits of the port address. Data of 2 or 4 bytes is byte-reversed on the way in and on the way out.

The block also guards the target. It drops accesses that fall beyond the target's configuration space and accesses made while no device is selected. It rejects malformed accesses to every other register and pulses an error flag for each rejected access. The configuration space port is combinational: the request appears in the same cycle as the bus request, and the read data is returned in that cycle. The bus response is registered and appears one cycle later.

Top module: `cfg_data_port`

## Requirements
- R1: The configuration offset sent to the target is `(addr_reg[43:32] & 0xFFC) | req_addr_i[1:0]`. The same formation is used for reads and for writes.
- R2: A data-port write of size code 0 (1 byte) sends its data unchanged. Size code 1 (2 bytes) sends the 16-bit byte reversal of `req_wdata_i[15:0]`. Size code 2 (4 bytes) sends the 32-bit byte reversal of `req_wdata_i[31:0]`. The target stores `cfg_wdata_o` byte k at offset+k.
- R3: A data-port read returns the same byte reversal of `cfg_rdata_i` for its size, right-justified in `rsp_rdata_o`, with all higher bits zero.
- R4: With `cfg_ext_i`=0 the configuration space holds 256 bytes; with `cfg_ext_i`=1 it holds 4096 bytes. At an offset at or beyond that size, a write is not forwarded and a read returns all ones (64 bits). Both raise `acc_err_o`.
- R5: While `dev_present_i` is 0, data-port reads return all ones and writes are not forwarded, without an error.
- R6: The data port answers at the register offsets whose bits 11:2 equal those of `DATA_PORT_OFF` (default 0x140). A data-port access with size code 3 (8 bytes) is rejected with `acc_err_o` and reads as zero.
- R7: Any other register access must use size code 3 at an offset with bits 2:0 zero. Otherwise it is ignored: the address register keeps its value, a read returns zero, and `acc_err_o` pulses.
- R8: The address register sits at `ADDR_REG_OFF` (default 0x130). It resets to zero and is read and written as a full 64-bit value. A data-port access in the cycle right after a write to it uses the new value. Other well-formed register offsets read zero without an error.
- R9: Each request produces exactly one `rsp_valid_o` pulse in the next cycle. `acc_err_o` is high only in that response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register bus request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Register byte offset |
| req_size_i | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_wdata_i | input | 64 | Write data, right-justified |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata_o | output | 64 | Read data |
| acc_err_o | output | 1 | Rejected-access pulse, in the response cycle |
| dev_present_i | input | 1 | A configuration target is selected |
| cfg_ext_i | input | 1 | 0 = 256-byte space, 1 = 4096-byte space |
| cfg_req_o | output | 1 | Configuration access strobe |
| cfg_we_o | output | 1 | Configuration write enable |
| cfg_addr_o | output | 12 | Configuration byte offset |
| cfg_size_o | output | 2 | Configuration access size code |
| cfg_wdata_o | output | 32 | Little-endian write data |
| cfg_rdata_i | input | 32 | Little-endian read data, same cycle |

## Verification
The address register can be written in one cycle and used by a data-port access in the very next cycle. The bench issues this pair back to back, with no idle cycle between them. The reference model expects the new offset to apply, so it checks the byte the target returns at the new location. The range check and the malformed-access check also meet in one response. Out-of-range accesses are mixed with misaligned and oversized accesses under both space sizes. For each response, the model judges the read data and the single error pulse together.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } acc_size_e;
endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode #(
  parameter int OFF_W         = 12,
  parameter int CFG_AW        = 12,
  parameter int FIELD_LSB     = 32,
  parameter int DW            = 64,
  parameter int ADDR_REG_OFF  = 'h130,
  parameter int DATA_PORT_OFF = 'h140,
  parameter int STD_LIMIT     = 256,
  parameter int EXT_LIMIT     = 4096
) (
  input  logic [OFF_W-1:0]  addr_i,
  input  logic [1:0]        size_i,
  input  logic [DW-1:0]     areg_i,
  input  logic              ext_i,
  output logic              is_dp_o,
  output logic              is_areg_o,
  output logic              bad_o,
  output logic [CFG_AW-1:0] cfg_off_o,
  output logic              oor_o
);
  import cfgp_pkg::*;
  localparam int LIM_W = CFG_AW + 1;
  localparam logic [OFF_W-1:0] DP_OFF = OFF_W'(DATA_PORT_OFF);
  localparam logic [OFF_W-1:0] AR_OFF = OFF_W'(ADDR_REG_OFF);

  logic              aligned8;
  logic [LIM_W-1:0]  limit;
  logic [CFG_AW-1:0] field;

  assign field     = areg_i[FIELD_LSB +: CFG_AW];
  assign is_dp_o   = (addr_i[OFF_W-1:2] == DP_OFF[OFF_W-1:2]);
  assign is_areg_o = (addr_i == AR_OFF);
  assign aligned8  = (acc_size_e'(size_i) == SZ_B8) && (addr_i[2:0] == 3'd0);
  assign bad_o     = is_dp_o ? (acc_size_e'(size_i) == SZ_B8) : !aligned8;
  // dword-align the stored offset, then merge the port's byte lane
  assign cfg_off_o = {field[CFG_AW-1:2], addr_i[1:0]};
  assign limit     = ext_i ? LIM_W'(EXT_LIMIT) : LIM_W'(STD_LIMIT);
  assign oor_o     = ({1'b0, cfg_off_o} >= limit);
endmodule

// File: rtl/cfgp_lane_swap.sv
module cfgp_lane_swap #(
  parameter int W = 32
) (
  input  logic [1:0]   size_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o
);
  import cfgp_pkg::*;
  localparam int NB = W / 8;

  logic [W-1:0] rev_h;
  logic [W-1:0] rev_w;

  assign rev_h[W-1:16] = '0;
  generate
    for (genvar b = 0; b < 2; b++) begin : g_half
      assign rev_h[8*b +: 8] = data_i[8*(1-b) +: 8];
    end
    for (genvar b = 0; b < NB; b++) begin : g_word
      assign rev_w[8*b +: 8] = data_i[8*(NB-1-b) +: 8];
    end
  endgenerate

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_B1:   data_o = {{(W-8){1'b0}}, data_i[7:0]};
      SZ_B2:   data_o = rev_h;
      default: data_o = rev_w;
    endcase
  end
endmodule

// File: rtl/cfg_data_port.sv
module cfg_data_port #(
  parameter int OFF_W         = 12,
  parameter int CFG_AW        = 12,
  parameter int FIELD_LSB     = 32,
  parameter int DW            = 64,
  parameter int CW            = 32,
  parameter int ADDR_REG_OFF  = 'h130,
  parameter int DATA_PORT_OFF = 'h140,
  parameter int STD_LIMIT     = 256,
  parameter int EXT_LIMIT     = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [OFF_W-1:0]  req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic              acc_err_o,
  input  logic              dev_present_i,
  input  logic              cfg_ext_i,
  output logic              cfg_req_o,
  output logic              cfg_we_o,
  output logic [CFG_AW-1:0] cfg_addr_o,
  output logic [1:0]        cfg_size_o,
  output logic [CW-1:0]     cfg_wdata_o,
  input  logic [CW-1:0]     cfg_rdata_i
);
  logic [DW-1:0]     areg_q;
  logic              is_dp, is_areg, bad, oor, dp_ok, dp_live;
  logic [CFG_AW-1:0] cfg_off;
  logic [CW-1:0]     rd_swapped;
  logic [DW-1:0]     rdata_d;
  logic              err_d;

  cfgp_decode #(
    .OFF_W(OFF_W), .CFG_AW(CFG_AW), .FIELD_LSB(FIELD_LSB), .DW(DW),
    .ADDR_REG_OFF(ADDR_REG_OFF), .DATA_PORT_OFF(DATA_PORT_OFF),
    .STD_LIMIT(STD_LIMIT), .EXT_LIMIT(EXT_LIMIT)
  ) i_decode (
    .addr_i(req_addr_i), .size_i(req_size_i), .areg_i(areg_q), .ext_i(cfg_ext_i),
    .is_dp_o(is_dp), .is_areg_o(is_areg), .bad_o(bad),
    .cfg_off_o(cfg_off), .oor_o(oor)
  );

  cfgp_lane_swap #(.W(CW)) i_wr_swap (
    .size_i(req_size_i), .data_i(req_wdata_i[CW-1:0]), .data_o(cfg_wdata_o)
  );

  cfgp_lane_swap #(.W(CW)) i_rd_swap (
    .size_i(req_size_i), .data_i(cfg_rdata_i), .data_o(rd_swapped)
  );

  assign dp_ok      = is_dp && !bad;
  assign dp_live    = dp_ok && dev_present_i;
  assign cfg_req_o  = req_valid_i && dp_live && !oor;
  assign cfg_we_o   = req_write_i;
  assign cfg_addr_o = cfg_off;
  assign cfg_size_o = req_size_i;

  always_comb begin
    rdata_d = '0;
    err_d   = bad || (dp_live && oor);
    if (!req_write_i && !bad) begin
      if (is_dp) begin
        if (!dev_present_i || oor) rdata_d = '1;
        else                       rdata_d = {{(DW-CW){1'b0}}, rd_swapped};
      end else if (is_areg) begin
        rdata_d = areg_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      areg_q      <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      acc_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      acc_err_o   <= req_valid_i && err_d;
      rsp_rdata_o <= req_valid_i ? rdata_d : '0;
      if (req_valid_i && req_write_i && is_areg && !bad) areg_q <= req_wdata_i;
    end
  end
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
  parameter int OFF_W         = 12,
  parameter int CFG_AW        = 12,
  parameter int DATA_PORT_OFF = 'h140,
  parameter int STD_LIMIT     = 256
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [OFF_W-1:0]  req_addr_i,
  input logic [1:0]        req_size_i,
  input logic              dev_present_i,
  input logic              cfg_ext_i,
  input logic              cfg_req_o,
  input logic [CFG_AW-1:0] cfg_addr_o,
  input logic [1:0]        cfg_size_o,
  input logic              rsp_valid_o,
  input logic              acc_err_o
);
  localparam logic [OFF_W-1:0] DP = OFF_W'(DATA_PORT_OFF);

  p_lane_bits_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> cfg_addr_o[1:0] == req_addr_i[1:0]);

  p_std_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_o && !cfg_ext_i) |-> ({1'b0, cfg_addr_o} < (CFG_AW+1)'(STD_LIMIT)));

  p_absent_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_present_i |-> !cfg_req_o);

  p_no_wide_cfg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> cfg_size_o != 2'd3);

  p_misaligned_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[OFF_W-1:2] != DP[OFF_W-1:2] && req_addr_i[2:0] != 3'd0)
      |=> acc_err_o);

  p_rsp_next_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_rsp_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  p_err_in_rsp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err_o |-> rsp_valid_o);
endmodule

bind cfg_data_port cfgp_checker #(
  .OFF_W(OFF_W), .CFG_AW(CFG_AW), .DATA_PORT_OFF(DATA_PORT_OFF), .STD_LIMIT(STD_LIMIT)
) i_cfgp_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
  .req_size_i(req_size_i), .dev_present_i(dev_present_i), .cfg_ext_i(cfg_ext_i),
  .cfg_req_o(cfg_req_o), .cfg_addr_o(cfg_addr_o), .cfg_size_o(cfg_size_o),
  .rsp_valid_o(rsp_valid_o), .acc_err_o(acc_err_o)
);

// File: tb/test_cfg_data_port.sv
`timescale 1ns/1ps
module test_cfg_data_port;
  localparam logic [11:0] AREG = 12'h130;
  localparam logic [11:0] DPRT = 12'h140;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, acc_err;
  logic [63:0] rsp_rdata;
  logic        dev_present = 1'b1, cfg_ext = 1'b0;
  logic        cfg_req, cfg_we;
  logic [11:0] cfg_addr;
  logic [1:0]  cfg_size;
  logic [31:0] cfg_wdata, cfg_rdata;

  always #4 clk = ~clk;

  cfg_data_port i_cfg_data_port (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .acc_err_o(acc_err),
    .dev_present_i(dev_present), .cfg_ext_i(cfg_ext),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_addr_o(cfg_addr),
    .cfg_size_o(cfg_size), .cfg_wdata_o(cfg_wdata), .cfg_rdata_i(cfg_rdata)
  );

  // target configuration space
  logic [7:0] tmem [4096];
  always_comb
    for (int k = 0; k < 4; k++) cfg_rdata[8*k +: 8] = tmem[(cfg_addr + 12'(k)) & 12'hFFF];
  always @(posedge clk)
    if (cfg_req && cfg_we)
      for (int k = 0; k < (1 << cfg_size); k++) tmem[(cfg_addr + 12'(k)) & 12'hFFF] <= cfg_wdata[8*k +: 8];

  // reference model state
  logic [7:0]  rmem [4096];
  logic [63:0] m_areg = '0;
  bit          e_valid = 0, e_err = 0;
  logic [63:0] e_rdata = '0;
  string       e_tag = "R9";
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  task automatic check_prev();
    n_chk++;
    if (rsp_valid !== e_valid || rsp_rdata !== e_rdata || acc_err !== e_err) begin
      n_fail++;
      $display("FAIL %s: got v=%0b d=%h e=%0b exp v=%0b d=%h e=%0b",
               e_tag, rsp_valid, rsp_rdata, acc_err, e_valid, e_rdata, e_err);
    end
  endtask

  task automatic model(input bit we, input logic [11:0] a, input logic [1:0] sz,
                       input logic [63:0] wd);
    int n = 1 << sz;
    int off;
    e_valid = 1; e_err = 0; e_rdata = '0;
    if (a[11:2] == DPRT[11:2]) begin
      if (sz == 2'd3) e_err = 1;
      else begin
        off = int'(m_areg[43:32] & 12'hFFC) + int'(a[1:0]);
        if (!dev_present) begin
          if (!we) e_rdata = '1;
        end else if (off >= (cfg_ext ? 4096 : 256)) begin
          e_err = 1;
          if (!we) e_rdata = '1;
        end else if (we) begin
          for (int k = 0; k < n; k++) rmem[off + k] = wd[8*(n-1-k) +: 8];
        end else begin
          for (int k = 0; k < n; k++) e_rdata[8*(n-1-k) +: 8] = rmem[off + k];
        end
      end
    end else if (sz != 2'd3 || a[2:0] != 3'd0) begin
      e_err = 1;
    end else if (a == AREG) begin
      if (we) m_areg = wd;
      else    e_rdata = m_areg;
    end
  endtask

  task automatic acc(input string tag, input bit we, input logic [11:0] a,
                     input logic [1:0] sz, input logic [63:0] wd);
    @(negedge clk);
    check_prev();
    req_valid = 1; req_write = we; req_addr = a; req_size = sz; req_wdata = wd;
    model(we, a, sz, wd);
    e_tag = tag;
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    check_prev();
    req_valid = 0; req_write = 0;
    e_valid = 0; e_err = 0; e_rdata = '0; e_tag = tag;
  endtask

  task automatic set_off(input string tag, input logic [11:0] o, input logic [19:0] junk);
    acc(tag, 1, AREG, 2'd3, {junk, o, 32'hA5A5_0000 | 32'(junk)});
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      tmem[i] = 8'(i * 7 + 3);
      rmem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    // R8 reset state
    n_chk++;
    if (rsp_valid !== 0 || acc_err !== 0 || rsp_rdata !== 0) begin
      n_fail++;
      $display("FAIL R8: reset outputs v=%0b e=%0b d=%h exp 0", rsp_valid, acc_err, rsp_rdata);
    end
    rst_n = 1;
    idle("R8");
    acc("R8", 0, AREG, 2'd3, 0);
    // R1/R2/R3 basic swaps, back-to-back address write then data access
    set_off("R8", 12'h010, 20'h0);
    acc("R2", 1, DPRT, 2'd2, 64'hFFFF_FFFF_1122_3344);
    acc("R3", 0, DPRT, 2'd2, 0);
    acc("R3", 0, DPRT + 12'd1, 2'd0, 0);
    acc("R3", 0, DPRT + 12'd2, 2'd1, 0);
    acc("R2", 1, DPRT + 12'd3, 2'd0, 64'h0000_0000_0000_00BE);
    acc("R2", 1, DPRT + 12'd2, 2'd1, 64'hDEAD_0000_0000_C0DE);
    acc("R3", 0, DPRT, 2'd2, 0);
    // R1 low bits of field masked away
    set_off("R1", 12'h013, 20'hFFFFF);
    acc("R1", 0, DPRT + 12'd1, 2'd0, 0);
    acc("R8", 0, AREG, 2'd3, 0);
    set_off("R1", 12'h022, 20'h12345);
    acc("R1", 1, DPRT + 12'd1, 2'd0, 64'h77);
    acc("R1", 0, DPRT, 2'd2, 0);
    // R4 limits
    set_off("R4", 12'h100, 20'h0);
    acc("R4", 1, DPRT, 2'd2, 64'hCAFE_F00D);
    acc("R4", 0, DPRT, 2'd2, 0);
    @(negedge clk); cfg_ext = 1; e_tag = "R4"; check_prev(); req_valid = 0; e_valid = 0; e_err = 0; e_rdata = 0;
    acc("R4", 0, DPRT, 2'd2, 0);
    acc("R4", 1, DPRT, 2'd2, 64'hCAFE_F00D);
    acc("R4", 0, DPRT, 2'd2, 0);
    set_off("R4", 12'hFFC, 20'h0);
    acc("R4", 1, DPRT + 12'd3, 2'd0, 64'h5A);
    acc("R4", 0, DPRT, 2'd2, 0);
    @(negedge clk); cfg_ext = 0; e_tag = "R4"; check_prev(); req_valid = 0; e_valid = 0; e_err = 0; e_rdata = 0;
    acc("R4", 0, DPRT + 12'd3, 2'd0, 0);
    set_off("R4", 12'h0FC, 20'h0);
    acc("R4", 0, DPRT + 12'd3, 2'd0, 0);
    // R5 no device
    @(negedge clk); dev_present = 0; e_tag = "R5"; check_prev(); req_valid = 0; e_valid = 0; e_err = 0; e_rdata = 0;
    acc("R5", 1, DPRT, 2'd2, 64'h0BAD_0BAD);
    acc("R5", 0, DPRT, 2'd1, 0);
    set_off("R5", 12'h300, 20'h0);
    acc("R5", 0, DPRT, 2'd2, 0);
    @(negedge clk); dev_present = 1; e_tag = "R5"; check_prev(); req_valid = 0; e_valid = 0; e_err = 0; e_rdata = 0;
    set_off("R5", 12'h0FC, 20'h0);
    acc("R5", 0, DPRT, 2'd2, 0);
    // R6 data port size 8
    acc("R6", 1, DPRT, 2'd3, 64'h1);
    acc("R6", 0, DPRT, 2'd3, 0);
    acc("R6", 0, DPRT, 2'd2, 0);
    // R7 malformed register accesses
    acc("R7", 1, AREG, 2'd2, 64'h0000_0055_0000_0000);
    acc("R7", 1, AREG + 12'd4, 2'd3, 64'h0000_0066_0000_0000);
    acc("R7", 0, AREG + 12'd2, 2'd3, 0);
    acc("R7", 0, AREG, 2'd0, 0);
    acc("R7", 0, AREG, 2'd3, 0);
    acc("R8", 0, 12'h200, 2'd3, 0);
    acc("R8", 1, 12'h208, 2'd3, 64'h1234);
    idle("R9");
    // mixed stream under both space sizes
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom_range(0, 9));
      logic [1:0] sz = 2'($urandom_range(0, 3));
      if (i % 50 == 0) begin
        @(negedge clk); cfg_ext = ~cfg_ext; dev_present = (i % 150) != 100;
        e_tag = "R4"; check_prev(); req_valid = 0; e_valid = 0; e_err = 0; e_rdata = 0;
      end
      if (r == 0) set_off("R8", 12'($urandom_range(0, 12'hFF8)), 20'($urandom));
      else if (r <= 6) acc("R2", r[0], DPRT + 12'($urandom_range(0, 3)), sz, {$urandom, $urandom});
      else if (r == 7) acc("R7", 0, AREG + 12'($urandom_range(0, 7)), sz, 0);
      else if (r == 8) acc("R8", 0, AREG, 2'd3, 0);
      else idle("R9");
    end
    idle("R9");
    idle("R9");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R9: watchdog expired, got running exp finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule